// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one cell of a programmable logic fabric. Two 4-input lookup tables evaluate arbitrary Boolean functions of their own input groups. A third, 3-input table combines the two table results with one extra input, which gives any function of five variables and some wider ones. Two combinational outputs leave the cell. Each one shows either a 4-input table result or the combining table result.

Two storage elements capture a selectable source: the direct data input or one of the three table results. Each can run as an edge-triggered flip-flop or, as a group, as level-sensitive latches. They share the clock, the clock enable and a local set/reset. A global set/reset overrides everything and loads a per-element start value. Both the clock polarity and the flip-flop/latch choice are configuration bits.

All table contents and selects live in a 52-bit configuration word. The word is shifted in serially while a configuration enable is held. The storage elements keep their contents for the whole load.

Top module: `clc_cell`

## Requirements
- R1: The F result is bit `f_in` of table F (config bits 15:0), and the G result is bit `g_in` of table G (config bits 31:16). Input 1 of each table is the least significant index bit.
- R2: The H result is bit {h1, G result, F result} of table H (config bits 39:32). The F result is index bit 0 and h1 is index bit 2.
- R3: `x` shows the H result when config bit 40 is 1 and the F result otherwise. `y` shows the H result when config bit 41 is 1 and the G result otherwise.
- R4: The source of the first storage element (`xq`) is set by config bits 43:42 and that of the second (`yq`) by bits 45:44. The codes are 0 = `din`, 1 = F, 2 = G and 3 = H. With H as the source, h1 can reach a storage element.
- R5: With config bit 51 = 0, the elements are flip-flops clocked on the rising edge of the effective clock, `clk` XOR config bit 50. They capture their source when `ec` is 1 and hold their value when `ec` is 0.
- R6: In flip-flop mode, `sr` high at an effective clock edge loads each element with its set/reset value. The value is config bit 46 for `xq` and bit 47 for `yq`. This overrides `ec` and the data.
- R7: `gsr` high forces `xq` to config bit 48 and `yq` to config bit 49 at once, in every mode, and overrides `sr`.
- R8: With config bit 51 = 1, both elements are latches. A latch follows its source while the effective clock is high and `ec` is 1, and holds otherwise. `sr` high forces the set/reset values at any time.
- R9: On each rising `clk` edge with `cfg_en` high, the configuration word shifts up by one bit and `cfg_din` enters bit 0. A word is therefore sent most significant bit first.
- R10: While `cfg_en` is high, `ec` and `sr` have no effect: the storage elements keep their contents through a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, also the configuration shift clock |
| gsr | input | 1 | Global set/reset, asynchronous, active high |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| f_in | input | LUT_K | Inputs of table F, bit 0 is input 1 |
| g_in | input | LUT_K | Inputs of table G, bit 0 is input 1 |
| h1 | input | 1 | Extra input of table H |
| din | input | 1 | Direct data input to the storage elements |
| ec | input | 1 | Shared clock enable |
| sr | input | 1 | Shared local set/reset |
| x | output | 1 | Combinational output, F or H |
| y | output | 1 | Combinational output, G or H |
| xq | output | 1 | First storage element output |
| yq | output | 1 | Second storage element output |

## Verification
Two pairs of controls can meet in the same cycle.

- **Local set/reset with enabled data.** The bench raises `sr` while `ec` is high and sets `din` and the table inputs so that the captured data would differ from the set/reset values. Only the configured set/reset value may appear.
- **Global set/reset with local set/reset.** The bench asserts `gsr` and `sr` together. Each element must show its global start value, not its set/reset value.

Both pairs are also exercised against a configuration reload. A reload with `sr` and `ec` held high must leave the stored bits untouched.

// File: rtl/clc_pkg.sv
package clc_pkg;

   // storage element data source codes
   typedef enum logic [1:0] {
      SRC_DIN = 2'd0,
      SRC_F   = 2'd1,
      SRC_G   = 2'd2,
      SRC_H   = 2'd3
   } clc_src_e;

   // control part of the configuration word, first field is the MSB
   typedef struct packed {
      logic     latch_mode;
      logic     clk_inv;
      logic     y_init;
      logic     x_init;
      logic     y_srv;
      logic     x_srv;
      clc_src_e y_src;
      clc_src_e x_src;
      logic     y_pick_h;
      logic     x_pick_h;
   } clc_ctl_t;

   localparam int unsigned CTL_W = $bits(clc_ctl_t);
   localparam int unsigned H_K   = 3;

endpackage

// File: rtl/clc_lut.sv
module clc_lut #(
   parameter int unsigned K = 4
) (
   input  logic [(1<<K)-1:0] tbl,
   input  logic [K-1:0]      sel,
   output logic              o
);
   localparam int unsigned N = 1 << K;

   generate
      if (K < 1 || K > 6) begin : g_bad_k
         $error("clc_lut: K out of range");
      end
   endgenerate

   logic [N-1:0] tbl_w;
   assign tbl_w = tbl;
   assign o     = tbl_w[sel];

endmodule

// File: rtl/clc_cfg.sv
module clc_cfg #(
   parameter int unsigned W = 52
) (
   input  logic         clk,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] word
);
   generate
      if (W < 2) begin : g_bad_w
         $error("clc_cfg: W too small");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (en) word <= {word[W-2:0], din};
   end

endmodule

// File: rtl/clc_store.sv
module clc_store #(
   parameter bit LATCH_EN = 1'b1
) (
   input  logic clk,
   input  logic gsr,
   input  logic ce,
   input  logic sr_go,
   input  logic d,
   input  logic clk_inv,
   input  logic latch_mode,
   input  logic sr_val,
   input  logic init_val,
   output logic q
);
   logic q_pos, q_neg, q_ff;

   // one register per clock polarity, selected by configuration
   always_ff @(posedge clk or posedge gsr) begin
      if (gsr)        q_pos <= init_val;
      else if (sr_go) q_pos <= sr_val;
      else if (ce)    q_pos <= d;
   end

   always_ff @(negedge clk or posedge gsr) begin
      if (gsr)        q_neg <= init_val;
      else if (sr_go) q_neg <= sr_val;
      else if (ce)    q_neg <= d;
   end

   assign q_ff = clk_inv ? q_neg : q_pos;

   generate
      if (LATCH_EN) begin : g_latch
         logic eclk;
         logic q_lat;
         assign eclk = clk ^ clk_inv;
         always_latch begin
            if (gsr)              q_lat = init_val;
            else if (sr_go)       q_lat = sr_val;
            else if (eclk && ce)  q_lat = d;
         end
         assign q = latch_mode ? q_lat : q_ff;
      end else begin : g_no_latch
         logic unused_mode;
         assign unused_mode = latch_mode;
         assign q = q_ff;
      end
   endgenerate

endmodule

// File: rtl/clc_cell.sv
module clc_cell
   import clc_pkg::*;
#(
   parameter int unsigned LUT_K    = 4,
   parameter bit          LATCH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             gsr,
   input  logic             cfg_en,
   input  logic             cfg_din,
   input  logic [LUT_K-1:0] f_in,
   input  logic [LUT_K-1:0] g_in,
   input  logic             h1,
   input  logic             din,
   input  logic             ec,
   input  logic             sr,
   output logic             x,
   output logic             y,
   output logic             xq,
   output logic             yq
);
   localparam int unsigned TBL   = 1 << LUT_K;
   localparam int unsigned H_TBL = 1 << H_K;
   localparam int unsigned F_LO  = 0;
   localparam int unsigned G_LO  = TBL;
   localparam int unsigned H_LO  = 2 * TBL;
   localparam int unsigned C_LO  = 2 * TBL + H_TBL;
   localparam int unsigned CFG_W = C_LO + CTL_W;

   generate
      if (LUT_K < 2 || LUT_K > 6) begin : g_bad_k
         $error("clc_cell: LUT_K must lie in 2..6");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q;
   clc_ctl_t         ctl;
   logic             f_o, g_o, h_o;
   logic             ce, sr_go;
   logic [1:0]       d_st, q_st, srv_st, init_st;
   clc_src_e         src_st [2];

   clc_cfg #(.W(CFG_W)) u_cfg (
      .clk  (clk),
      .en   (cfg_en),
      .din  (cfg_din),
      .word (cfg_q)
   );

   assign ctl = clc_ctl_t'(cfg_q[C_LO +: CTL_W]);

   clc_lut #(.K(LUT_K)) u_lut_f (
      .tbl (cfg_q[F_LO +: TBL]),
      .sel (f_in),
      .o   (f_o)
   );

   clc_lut #(.K(LUT_K)) u_lut_g (
      .tbl (cfg_q[G_LO +: TBL]),
      .sel (g_in),
      .o   (g_o)
   );

   clc_lut #(.K(H_K)) u_lut_h (
      .tbl (cfg_q[H_LO +: H_TBL]),
      .sel ({h1, g_o, f_o}),
      .o   (h_o)
   );

   assign x = ctl.x_pick_h ? h_o : f_o;
   assign y = ctl.y_pick_h ? h_o : g_o;

   // controls are frozen while the word is being shifted
   assign ce    = ec & ~cfg_en;
   assign sr_go = sr & ~cfg_en;

   assign src_st[0] = ctl.x_src;
   assign src_st[1] = ctl.y_src;
   assign srv_st    = {ctl.y_srv, ctl.x_srv};
   assign init_st   = {ctl.y_init, ctl.x_init};

   generate
      for (genvar i = 0; i < 2; i++) begin : g_elem
         always_comb begin
            case (src_st[i])
               SRC_F:   d_st[i] = f_o;
               SRC_G:   d_st[i] = g_o;
               SRC_H:   d_st[i] = h_o;
               default: d_st[i] = din;
            endcase
         end

         clc_store #(.LATCH_EN(LATCH_EN)) u_store (
            .clk        (clk),
            .gsr        (gsr),
            .ce         (ce),
            .sr_go      (sr_go),
            .d          (d_st[i]),
            .clk_inv    (ctl.clk_inv),
            .latch_mode (ctl.latch_mode),
            .sr_val     (srv_st[i]),
            .init_val   (init_st[i]),
            .q          (q_st[i])
         );
      end
   endgenerate

   assign xq = q_st[0];
   assign yq = q_st[1];

endmodule

// File: rtl/clc_cell_chk.sv
module clc_cell_chk
   import clc_pkg::*;
#(
   parameter int unsigned LUT_K    = 4,
   parameter bit          LATCH_EN = 1'b1
) (
   input logic             clk,
   input logic             gsr,
   input logic             cfg_en,
   input logic             ec,
   input logic             sr,
   input logic             din,
   input logic [LUT_K-1:0] f_in,
   input logic             x,
   input logic             xq,
   input logic             yq,
   input logic [2*(1<<LUT_K)+(1<<H_K)+CTL_W-1:0] cfg_q
);
   localparam int unsigned TBL  = 1 << LUT_K;
   localparam int unsigned C_LO = 2 * TBL + (1 << H_K);

   clc_ctl_t       ctl;
   logic [TBL-1:0] f_tbl;
   assign ctl   = clc_ctl_t'(cfg_q[C_LO +: CTL_W]);
   assign f_tbl = cfg_q[TBL-1:0];

   assert_f_lookup_R1: assert property (@(negedge clk) disable iff (cfg_en)
      !ctl.x_pick_h |-> (x == f_tbl[f_in]));

   assert_gsr_init_R7: assert property (@(negedge clk) disable iff (cfg_en)
      gsr |-> (xq == ctl.x_init && yq == ctl.y_init));

   assert_sr_wins_R6: assert property (@(posedge clk) disable iff (gsr || cfg_en)
      (sr && !ctl.latch_mode && !ctl.clk_inv)
      |=> (xq == $past(ctl.x_srv) && yq == $past(ctl.y_srv)));

   assert_hold_no_ec_R5: assert property (@(posedge clk) disable iff (gsr || cfg_en)
      (!sr && !ec && !ctl.latch_mode && !ctl.clk_inv)
      |=> ($stable(xq) && $stable(yq)));

   assert_din_capture_R5: assert property (@(posedge clk) disable iff (gsr || cfg_en)
      (ec && !sr && !ctl.latch_mode && !ctl.clk_inv && ctl.x_src == SRC_DIN)
      |=> (xq == $past(din)));

   generate
      if (LATCH_EN) begin : g_latch_chk
         assert_latch_open_R8: assert property (@(negedge clk) disable iff (gsr || cfg_en)
            (ctl.latch_mode && ctl.clk_inv && ec && !sr && ctl.x_src == SRC_DIN)
            |-> (xq == din));
      end
   endgenerate

endmodule

bind clc_cell clc_cell_chk #(.LUT_K(LUT_K), .LATCH_EN(LATCH_EN)) i_chk (
   .clk    (clk),
   .gsr    (gsr),
   .cfg_en (cfg_en),
   .ec     (ec),
   .sr     (sr),
   .din    (din),
   .f_in   (f_in),
   .x      (x),
   .xq     (xq),
   .yq     (yq),
   .cfg_q  (cfg_q)
);

// File: tb/test_clc_cell.sv
module test_clc_cell;
   localparam int PERIOD = 10;

   // layout: latch, inv, y_init, x_init, y_srv, x_srv, y_src, x_src, y_h, x_h, H, G, F
   localparam logic [51:0] CFG_A = {1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'd3,2'd0,1'b1,1'b0,8'hE8,16'h6996,16'hA5C3};
   localparam logic [51:0] CFG_B = {1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'd2,2'd3,1'b0,1'b1,8'hF0,16'h8001,16'h7FFE};
   localparam logic [51:0] CFG_C = {1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,2'd1,2'd0,1'b1,1'b1,8'h96,16'hF00F,16'h3C3C};
   localparam logic [51:0] CFG_D = {1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,2'd1,2'd0,1'b1,1'b1,8'h96,16'hF00F,16'h3C3C};

   logic clk = 1'b0;
   always #(PERIOD/2) clk = ~clk;

   logic       gsr = 1'b1, cfg_en = 1'b0, cfg_din = 1'b0;
   logic       h1 = 1'b0, din = 1'b0, ec = 1'b0, sr = 1'b0;
   logic [3:0] f_in = 4'd0, g_in = 4'd0;
   logic       x, y, xq, yq;

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;
   string phase  = "R7";

   logic [51:0] mw = '0;
   logic        mq [2];

   clc_cell i_clc_cell (
      .clk(clk), .gsr(gsr), .cfg_en(cfg_en), .cfg_din(cfg_din),
      .f_in(f_in), .g_in(g_in), .h1(h1), .din(din), .ec(ec), .sr(sr),
      .x(x), .y(y), .xq(xq), .yq(yq)
   );

   // behavioural reference
   function automatic logic m_f();
      return mw[int'(f_in)];
   endfunction
   function automatic logic m_g();
      return mw[16 + int'(g_in)];
   endfunction
   function automatic logic m_h();
      return mw[32 + int'({h1, m_g(), m_f()})];
   endfunction
   function automatic logic m_d(input int i);
      logic [1:0] s;
      s = (i == 0) ? mw[43:42] : mw[45:44];
      case (s)
         2'd1:    return m_f();
         2'd2:    return m_g();
         2'd3:    return m_h();
         default: return din;
      endcase
   endfunction

   task automatic m_apply(input bit lat_open, input bit ff_edge);
      for (int i = 0; i < 2; i++) begin
         if (gsr) mq[i] = mw[48+i];
         else if (mw[51]) begin
            if (!cfg_en && sr)                   mq[i] = mw[46+i];
            else if (lat_open && ec && !cfg_en)  mq[i] = m_d(i);
         end else if (ff_edge && !cfg_en) begin
            if (sr)      mq[i] = mw[46+i];
            else if (ec) mq[i] = m_d(i);
         end
      end
   endtask

   // every clock edge: a falling effective clock closes latches, a rising one clocks flops
   always @(clk) m_apply(!(clk ^ mw[50]), clk ^ mw[50]);

   task automatic chk(input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", phase, what, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #7;
      m_apply(clk ^ mw[50], 1'b0);
      chk("x",  x,  mw[40] ? m_h() : m_f());
      chk("y",  y,  mw[41] ? m_h() : m_g());
      chk("xq", xq, mq[0]);
      chk("yq", yq, mq[1]);
   endtask

   // R9: most significant bit first, one bit per rising clk
   task automatic load(input logic [51:0] w);
      cfg_en = 1'b1;
      for (int i = 51; i >= 0; i--) begin
         cfg_din = w[i];
         @(posedge clk);
         #7;
      end
      cfg_en = 1'b0;
      mw     = w;
   endtask

   task automatic rand_in();
      f_in = 4'($urandom);
      g_in = 4'($urandom);
      h1   = 1'($urandom);
      din  = 1'($urandom);
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // configuration A under global set/reset
      load(CFG_A);
      phase = "R9"; tick();
      phase = "R7"; tick();
      gsr = 1'b0;
      ec  = 1'b1;
      phase = "R1"; repeat (12) begin rand_in(); tick(); end
      phase = "R2"; repeat (8)  begin rand_in(); tick(); end
      phase = "R3"; repeat (8)  begin rand_in(); tick(); end
      // exhaustive sweep of table F
      phase = "R1";
      for (int k = 0; k < 16; k++) begin f_in = 4'(k); tick(); end
      phase = "R5"; ec = 1'b0;
      repeat (6) begin rand_in(); tick(); end
      // R6: local set/reset meets enabled data of the opposite value
      phase = "R6"; ec = 1'b1; sr = 1'b1;
      din = 1'b0; tick(); din = 1'b1; rand_in(); tick(); tick();
      sr = 1'b0; rand_in(); tick();
      // R7: global and local set/reset together
      phase = "R7"; gsr = 1'b1; sr = 1'b1; tick(); tick();
      gsr = 1'b0; tick();
      sr = 1'b0; tick();

      // R10: reload same word with sr and ec held, stored bits must survive
      phase = "R10"; din = 1'b0; ec = 1'b1; tick();
      sr = 1'b1; din = 1'b1;
      load(CFG_A);
      sr = 1'b0; ec = 1'b0; tick(); tick();

      // configuration B: inverted clock, H and G feed storage
      gsr = 1'b1;
      load(CFG_B);
      phase = "R7"; tick();
      gsr = 1'b0;
      phase = "R4"; ec = 1'b1;
      repeat (12) begin rand_in(); tick(); end
      phase = "R5";
      repeat (16) begin rand_in(); ec = 1'($urandom); sr = (($urandom % 5) == 0); tick(); end
      sr = 1'b0;

      // configuration C: latches, normal polarity
      gsr = 1'b1;
      load(CFG_C);
      phase = "R7"; tick();
      gsr = 1'b0;
      phase = "R8";
      repeat (16) begin rand_in(); ec = 1'($urandom); sr = (($urandom % 6) == 0); tick(); end
      sr = 1'b0;

      // configuration D: latches, inverted polarity
      gsr = 1'b1;
      load(CFG_D);
      tick();
      gsr = 1'b0;
      repeat (16) begin rand_in(); ec = 1'($urandom); sr = (($urandom % 6) == 0); tick(); end
      sr = 1'b1; ec = 1'b1; tick();
      sr = 1'b0; ec = 1'b0; rand_in(); tick();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule